// File: doc/BRIEF.md
# I2C Bus Status and Interrupt Unit

This unit sits next to an I2C byte engine and keeps the status a processor needs about the bus and the transfer in progress. It passes the serial clock and data lines through a synchronizer and finds START and STOP conditions in them. A three-state bus tracker records whether the bus is free, in use by this interface, or in use by another master. Only the third case raises the busy flag.

The byte engine sends one-cycle event strobes to the unit: byte transmitted, byte received, arbitration lost, general call seen, and the ACK/NAK bit of the byte. The unit stores the events as sticky interrupt flags and masks them with per-source enables into a single request line. It latches the last ACK/NAK bit. It turns the software ACK-to-send setting into the level actually driven on SDA, and the meaning of that setting depends on master or slave mode. Write-one-to-start read and write commands become start strobes to the byte engine, but only in master mode.

Bus tracker states: `BUS_IDLE` (no transaction), `BUS_FOREIGN` (transaction owned by another master), `BUS_OWN` (transaction owned by this interface). Transitions: `BUS_IDLE` goes to `BUS_OWN` on START while `own_active` is high, and to `BUS_FOREIGN` on START while it is low. `BUS_FOREIGN` and `BUS_OWN` both go to `BUS_IDLE` on STOP, and STOP takes priority. Without a STOP, `BUS_FOREIGN` goes to `BUS_OWN` when `own_active` rises, and `BUS_OWN` goes to `BUS_FOREIGN` when it falls. A repeated START keeps the current state.

Top module: `i2cmon_top`

## Requirements
- R1: After reset, `irq_flags` is 0, `irq_req` is 0, `busy_foreign` is 0, `ack_status` is 1, and `start_rd`, `start_wr`, `bus_start` and `bus_stop` are all 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Both lines pass through a two-stage synchronizer. `bus_start` pulses for one cycle in the second clock cycle after the SDA change. With `own_active` low, `busy_foreign` goes to 1 one cycle later. A STOP returns `busy_foreign` to 0.
- R3: While the bus is active, `busy_foreign` is 0 whenever `own_active` is high. It goes back to 1 one cycle after `own_active` falls, if no STOP has been seen.
- R4: SDA changes while SCL is low do not change `busy_foreign`. A repeated START keeps the bus active.
- R5: `ev_tx_done` sets `irq_flags[0]` and `ev_rx_done` sets `irq_flags[1]`, one cycle after the strobe. A flag stays set until a 1 is written to the same bit of `irq_clr`. When a set and a clear happen in the same cycle, the set wins.
- R6: `irq_req` is the OR over all bits of `irq_flags & irq_en`. The bit order is 0 for TX, 1 for RX, 2 for arbitration lost and 3 for general call. A flag whose enable is 0 still sets, but it does not raise `irq_req`.
- R7: `ev_arb_lost` sets `irq_flags[2]` only when `mode_master` is 1.
- R8: `ev_gen_call` sets `irq_flags[3]` only when `mode_master` is 0.
- R9: `ev_ack_valid` loads `ev_ack_bit` into `ack_status` one cycle later. A value of 0 means ACK and 1 means NAK. At all other times `ack_status` holds.
- R10: `ack_drive` is the SDA level for the ACK slot, with 0 meaning ACK and 1 meaning NACK. In master mode it equals `ack_send_cfg`. In slave mode it equals the inverse of `ack_send_cfg`.
- R11: In master mode, a 1 on `cmd_rd` alone gives a one-cycle `start_rd` in the next cycle. A 1 on `cmd_wr` alone gives a one-cycle `start_wr` in the same way.
- R12: In slave mode, `cmd_rd` and `cmd_wr` are ignored. A 1 on both in the same cycle is also ignored. In both cases no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| own_active | input | 1 | From the byte engine: this interface owns the current transaction |
| irq_en | input | 4 | Interrupt enables: [0] TX, [1] RX, [2] arbitration lost, [3] general call |
| irq_clr | input | 4 | Write-one-to-clear for `irq_flags` |
| ev_tx_done | input | 1 | Strobe: byte transmitted |
| ev_rx_done | input | 1 | Strobe: data byte received |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| ev_gen_call | input | 1 | Strobe: general call address matched |
| ev_ack_valid | input | 1 | Strobe: ACK/NAK bit of the byte is valid |
| ev_ack_bit | input | 1 | ACK/NAK bit seen on the bus (0 = ACK) |
| ack_send_cfg | input | 1 | Software ACK-to-send setting |
| cmd_rd | input | 1 | Write-one-to-start a read byte transfer |
| cmd_wr | input | 1 | Write-one-to-start a write byte transfer |
| start_rd | output | 1 | One-cycle read start strobe to the byte engine |
| start_wr | output | 1 | One-cycle write start strobe to the byte engine |
| ack_drive | output | 1 | SDA level to drive in the ACK slot |
| ack_status | output | 1 | Last ACK/NAK bit (1 = NAK) |
| busy_foreign | output | 1 | Bus active and owned by another master |
| bus_start | output | 1 | START detected pulse |
| bus_stop | output | 1 | STOP detected pulse |
| irq_flags | output | 4 | Sticky interrupt flags |
| irq_req | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is telling a repeated START and SDA data toggles apart from a real STOP while the bus belongs to another master. The stimulus first opens a foreign transaction. It then drops SCL and moves SDA several times, raises SCL with SDA high, and pulls SDA low for a repeated START. Only after that does it give a real STOP. Between steps it lets the synchronizer settle and checks `busy_foreign`. Handing the bus back and forth with `own_active` in the middle of a transaction is checked in the same way.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int IRQ_N   = 4;
    localparam int IRQ_TX  = 0;
    localparam int IRQ_RX  = 1;
    localparam int IRQ_ARB = 2;
    localparam int IRQ_GC  = 3;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_FOREIGN = 2'd1,
        BUS_OWN     = 2'd2
    } bus_state_e;

endpackage

// File: rtl/i2cmon_cond.sv
module i2cmon_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_pulse,
    output logic stop_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_s;
    logic                   sda_s;
    logic                   scl_d;
    logic                   sda_d;

    // synchronizer chain, one flop per stage
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[i] <= 1'b1;
                    sda_q[i] <= 1'b1;
                end else begin
                    scl_q[i] <= scl_in;
                    sda_q[i] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[i] <= 1'b1;
                    sda_q[i] <= 1'b1;
                end else begin
                    scl_q[i] <= scl_q[i-1];
                    sda_q[i] <= sda_q[i-1];
                end
            end
        end
    end

    assign scl_s = scl_q[LAST];
    assign sda_s = sda_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SCL must be high on both sides of the SDA edge
    always_comb begin
        start_pulse = scl_s & scl_d &  sda_d & ~sda_s;
        stop_pulse  = scl_s & scl_d & ~sda_d &  sda_s;
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_stop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

endmodule

// File: rtl/i2cmon_bus_fsm.sv
module i2cmon_bus_fsm
    import i2cmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_pulse,
    input  logic stop_pulse,
    input  logic own_active,
    output logic busy_foreign
);

    bus_state_e state_q;
    bus_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (start_pulse) state_d = own_active ? BUS_OWN : BUS_FOREIGN;
            end
            BUS_FOREIGN: begin
                if (stop_pulse)      state_d = BUS_IDLE;
                else if (own_active) state_d = BUS_OWN;
            end
            BUS_OWN: begin
                if (stop_pulse)       state_d = BUS_IDLE;
                else if (!own_active) state_d = BUS_FOREIGN;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUS_FOREIGN: busy_foreign = 1'b1;
            default:     busy_foreign = 1'b0;
        endcase
    end

    assert_stop_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !busy_foreign);
    assert_start_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !own_active) |=> busy_foreign);
    assert_own_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_foreign && own_active) |=> !busy_foreign);

endmodule

// File: rtl/i2cmon_irq.sv
module i2cmon_irq
    import i2cmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_master,
    input  logic             ev_tx_done,
    input  logic             ev_rx_done,
    input  logic             ev_arb_lost,
    input  logic             ev_gen_call,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic [IRQ_N-1:0] irq_flags,
    output logic             irq_req
);

    logic [IRQ_N-1:0] set_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[IRQ_TX]  = ev_tx_done;
        set_vec[IRQ_RX]  = ev_rx_done;
        set_vec[IRQ_ARB] = ev_arb_lost &  mode_master;
        set_vec[IRQ_GC]  = ev_gen_call & ~mode_master;
    end

    // a set in the same cycle as a clear wins
    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          irq_flags[i] <= 1'b0;
            else if (set_vec[i]) irq_flags[i] <= 1'b1;
            else if (irq_clr[i]) irq_flags[i] <= 1'b0;
        end
    end

    assign irq_req = |(irq_flags & irq_en);

    assert_tx_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> irq_flags[IRQ_TX]);
    assert_rx_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> irq_flags[IRQ_RX]);
    assert_arb_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !irq_flags[IRQ_ARB]) |=> !irq_flags[IRQ_ARB]);
    assert_gc_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !irq_flags[IRQ_GC]) |=> !irq_flags[IRQ_GC]);

endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             mode_master,
    input  logic             own_active,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic [IRQ_N-1:0] irq_clr,
    input  logic             ev_tx_done,
    input  logic             ev_rx_done,
    input  logic             ev_arb_lost,
    input  logic             ev_gen_call,
    input  logic             ev_ack_valid,
    input  logic             ev_ack_bit,
    input  logic             ack_send_cfg,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    output logic             start_rd,
    output logic             start_wr,
    output logic             ack_drive,
    output logic             ack_status,
    output logic             busy_foreign,
    output logic             bus_start,
    output logic             bus_stop,
    output logic [IRQ_N-1:0] irq_flags,
    output logic             irq_req
);

    logic start_pulse;
    logic stop_pulse;
    logic rd_ok;
    logic wr_ok;

    i2cmon_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

    i2cmon_bus_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_pulse  (start_pulse),
        .stop_pulse   (stop_pulse),
        .own_active   (own_active),
        .busy_foreign (busy_foreign)
    );

    i2cmon_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_master (mode_master),
        .ev_tx_done  (ev_tx_done),
        .ev_rx_done  (ev_rx_done),
        .ev_arb_lost (ev_arb_lost),
        .ev_gen_call (ev_gen_call),
        .irq_en      (irq_en),
        .irq_clr     (irq_clr),
        .irq_flags   (irq_flags),
        .irq_req     (irq_req)
    );

    assign bus_start = start_pulse;
    assign bus_stop  = stop_pulse;

    // the slave-mode ACK setting has the opposite sense
    assign ack_drive = mode_master ? ack_send_cfg : ~ack_send_cfg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ack_status <= 1'b1;
        else if (ev_ack_valid) ack_status <= ev_ack_bit;
    end

    // conflicting or slave-mode commands are dropped
    always_comb begin
        rd_ok = mode_master & cmd_rd & ~cmd_wr;
        wr_ok = mode_master & cmd_wr & ~cmd_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_rd <= 1'b0;
            start_wr <= 1'b0;
        end else begin
            start_rd <= rd_ok;
            start_wr <= wr_ok;
        end
    end

    assert_ack_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack_valid |=> (ack_status == $past(ev_ack_bit)));
    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ack_valid |=> $stable(ack_status));
    assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && cmd_rd && !cmd_wr) |=> (start_rd && !start_wr));
    assert_slave_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && (cmd_rd || cmd_wr)) |=> !(start_rd || start_wr));

endmodule

// File: tb/i2cmon_top_bench.sv
module i2cmon_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       mode_master = 1'b1, own_active = 1'b0;
    logic [3:0] irq_en = '0, irq_clr = '0;
    logic       ev_tx_done = 0, ev_rx_done = 0, ev_arb_lost = 0, ev_gen_call = 0;
    logic       ev_ack_valid = 0, ev_ack_bit = 0, ack_send_cfg = 0;
    logic       cmd_rd = 0, cmd_wr = 0;
    logic       start_rd, start_wr, ack_drive, ack_status, busy_foreign;
    logic       bus_start, bus_stop, irq_req;
    logic [3:0] irq_flags;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2cmon_top u_i2cmon_top (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .mode_master(mode_master), .own_active(own_active),
        .irq_en(irq_en), .irq_clr(irq_clr),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .ev_arb_lost(ev_arb_lost), .ev_gen_call(ev_gen_call),
        .ev_ack_valid(ev_ack_valid), .ev_ack_bit(ev_ack_bit),
        .ack_send_cfg(ack_send_cfg), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .start_rd(start_rd), .start_wr(start_wr), .ack_drive(ack_drive),
        .ack_status(ack_status), .busy_foreign(busy_foreign),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .irq_flags(irq_flags), .irq_req(irq_req)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setbus(logic c, logic d);
        scl_in = c;
        sda_in = d;
        cyc(4);
    endtask

    task automatic t_reset();
        chk("R1 flags", {4'd0, irq_flags}, 8'h0);
        chk("R1 irq_req", {7'd0, irq_req}, 8'h0);
        chk("R1 busy", {7'd0, busy_foreign}, 8'h0);
        chk("R1 ack_status", {7'd0, ack_status}, 8'h1);
        chk("R1 strobes", {4'd0, start_rd, start_wr, bus_start, bus_stop}, 8'h0);
    endtask

    task automatic t_start_stop();
        own_active = 0;
        sda_in = 1'b0;
        cyc(1);
        chk("R2 no start yet", {7'd0, bus_start}, 8'h0);
        cyc(1);
        chk("R2 start pulse", {7'd0, bus_start}, 8'h1);
        chk("R2 busy not yet", {7'd0, busy_foreign}, 8'h0);
        cyc(1);
        chk("R2 busy set", {7'd0, busy_foreign}, 8'h1);
        chk("R2 start single", {7'd0, bus_start}, 8'h0);
        setbus(1'b0, 1'b0);
        scl_in = 1'b1;
        cyc(4);
        sda_in = 1'b1;
        cyc(2);
        chk("R2 stop pulse", {7'd0, bus_stop}, 8'h1);
        cyc(1);
        chk("R2 busy cleared", {7'd0, busy_foreign}, 8'h0);
        cyc(2);
    endtask

    task automatic t_data_toggle();
        setbus(1'b1, 1'b0);
        chk("R4 foreign open", {7'd0, busy_foreign}, 8'h1);
        setbus(1'b0, 1'b0);
        setbus(1'b0, 1'b1);
        setbus(1'b0, 1'b0);
        setbus(1'b0, 1'b1);
        chk("R4 toggles with SCL low", {7'd0, busy_foreign}, 8'h1);
        setbus(1'b1, 1'b1);
        setbus(1'b1, 1'b0);
        chk("R4 repeated start", {7'd0, busy_foreign}, 8'h1);
        setbus(1'b0, 1'b0);
        setbus(1'b1, 1'b0);
        setbus(1'b1, 1'b1);
        chk("R4 stop after toggles", {7'd0, busy_foreign}, 8'h0);
    endtask

    task automatic t_own();
        own_active = 1'b1;
        setbus(1'b1, 1'b0);
        chk("R3 own start not busy", {7'd0, busy_foreign}, 8'h0);
        own_active = 1'b0;
        cyc(1);
        chk("R3 release to foreign", {7'd0, busy_foreign}, 8'h1);
        own_active = 1'b1;
        cyc(1);
        chk("R3 take back", {7'd0, busy_foreign}, 8'h0);
        setbus(1'b0, 1'b0);
        setbus(1'b1, 1'b0);
        setbus(1'b1, 1'b1);
        own_active = 1'b0;
        cyc(1);
        chk("R3 idle after stop", {7'd0, busy_foreign}, 8'h0);
    endtask

    task automatic t_flags();
        irq_en = 4'b0000;
        ev_tx_done = 1;
        cyc(1);
        ev_tx_done = 0;
        chk("R5 tx flag", {4'd0, irq_flags}, 8'h1);
        chk("R6 masked", {7'd0, irq_req}, 8'h0);
        ev_rx_done = 1;
        cyc(1);
        ev_rx_done = 0;
        cyc(2);
        chk("R5 sticky", {4'd0, irq_flags}, 8'h3);
        irq_en = 4'b0010;
        #1;
        chk("R6 rx enabled", {7'd0, irq_req}, 8'h1);
        irq_clr = 4'b0010;
        cyc(1);
        irq_clr = 4'b0000;
        chk("R5 clear rx", {4'd0, irq_flags}, 8'h1);
        chk("R6 req drops", {7'd0, irq_req}, 8'h0);
        ev_tx_done = 1;
        irq_clr = 4'b0001;
        cyc(1);
        ev_tx_done = 0;
        irq_clr = 4'b0000;
        chk("R5 set beats clear", {4'd0, irq_flags}, 8'h1);
        irq_clr = 4'b1111;
        cyc(1);
        irq_clr = 4'b0000;
        chk("R5 clear all", {4'd0, irq_flags}, 8'h0);
    endtask

    task automatic t_arb_gc();
        irq_en = 4'b1100;
        mode_master = 0;
        ev_arb_lost = 1;
        cyc(1);
        ev_arb_lost = 0;
        chk("R7 arb ignored in slave", {4'd0, irq_flags}, 8'h0);
        ev_gen_call = 1;
        cyc(1);
        ev_gen_call = 0;
        chk("R8 gc in slave", {4'd0, irq_flags}, 8'h8);
        chk("R6 gc req", {7'd0, irq_req}, 8'h1);
        irq_clr = 4'b1000;
        mode_master = 1;
        cyc(1);
        irq_clr = 4'b0000;
        ev_gen_call = 1;
        cyc(1);
        ev_gen_call = 0;
        chk("R8 gc ignored in master", {4'd0, irq_flags}, 8'h0);
        ev_arb_lost = 1;
        cyc(1);
        ev_arb_lost = 0;
        chk("R7 arb in master", {4'd0, irq_flags}, 8'h4);
        chk("R6 arb req", {7'd0, irq_req}, 8'h1);
        irq_clr = 4'b1111;
        cyc(1);
        irq_clr = 4'b0000;
    endtask

    task automatic t_ack();
        ev_ack_bit = 0;
        ev_ack_valid = 1;
        cyc(1);
        ev_ack_valid = 0;
        chk("R9 ack captured", {7'd0, ack_status}, 8'h0);
        ev_ack_bit = 1;
        cyc(2);
        chk("R9 holds", {7'd0, ack_status}, 8'h0);
        ev_ack_valid = 1;
        cyc(1);
        ev_ack_valid = 0;
        chk("R9 nak captured", {7'd0, ack_status}, 8'h1);
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 2; c++) begin
                mode_master = m[0];
                ack_send_cfg = c[0];
                #1;
                chk("R10 ack drive", {7'd0, ack_drive}, {7'd0, (m[0] ? c[0] : ~c[0])});
            end
        end
        mode_master = 1;
        ack_send_cfg = 0;
        cyc(1);
    endtask

    task automatic t_cmds();
        mode_master = 1;
        cmd_rd = 1;
        cyc(1);
        cmd_rd = 0;
        chk("R11 start_rd", {6'd0, start_rd, start_wr}, 8'h2);
        cyc(1);
        chk("R11 rd one cycle", {6'd0, start_rd, start_wr}, 8'h0);
        cmd_wr = 1;
        cyc(1);
        cmd_wr = 0;
        chk("R11 start_wr", {6'd0, start_rd, start_wr}, 8'h1);
        cmd_rd = 1;
        cmd_wr = 1;
        cyc(1);
        cmd_rd = 0;
        cmd_wr = 0;
        chk("R12 both dropped", {6'd0, start_rd, start_wr}, 8'h0);
        mode_master = 0;
        cmd_rd = 1;
        cyc(1);
        cmd_rd = 0;
        chk("R12 slave rd ignored", {6'd0, start_rd, start_wr}, 8'h0);
        cmd_wr = 1;
        cyc(1);
        cmd_wr = 0;
        chk("R12 slave wr ignored", {6'd0, start_rd, start_wr}, 8'h0);
        mode_master = 1;
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_start_stop();
        t_data_toggle();
        t_own();
        t_flags();
        t_arb_gc();
        t_ack();
        t_cmds();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule